// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table with Pending Replay

This block holds a table of per-vector interrupt messages and an array of pending bits, both in one memory-mapped region on a 32-bit register bus. Each vector entry carries a 64-bit message address, a 32-bit message payload and a control word whose bit 0 masks the vector. When the device raises one of its interrupt request lines, the block either sends that vector's message over a valid/ready output handshake or, if the vector or the whole function is masked, records the request as a pending bit.

A pending request is not lost. It is replayed when software rewrites that vector's entry while the vector is unmasked, or when a rescan request walks every vector from the lowest index upward. Requests that arrive while a message is waiting for acceptance are queued the same way. The scan serves one vector per message. The output therefore carries at most one message at a time.

Top module: `msix_vec_table`

## Requirements
- R1: After reset every control dword reads 1 (masked), every other table dword reads 0, the pending dword reads 0 and `msg_valid` is low.
- R2: Vector i occupies bytes 16i to 16i+15, as four dwords: address low at +0, address high at +4, payload at +8, control at +12. A write to an aligned address below the pending offset stores the whole dword, and a later read returns it.
- R3: A message carries `msg_addr` = {address high, address low with bits 1:0 cleared} and `msg_data` = the payload of its vector.
- R4: The pending array starts at byte 16·NVEC. Vector i is bit i mod 32 of the dword at 16·NVEC + 4·(i/32), and unused bits read 0. The region is 16·NVEC + ceil(NVEC/8) bytes, rounded up to a multiple of 4096. Reads at or beyond its end return 0xFFFFFFFF. Other reads inside the region that hit neither table nor pending array return 0.
- R5: An access with bus address bits 1:0 not zero is not accepted: a read returns 0xFFFFFFFF and a write changes nothing. A write at or beyond the pending offset changes nothing.
- R6: A request counts only on a 0-to-1 transition of `irq_req[i]` while `fn_enable` is high. A level held high yields one message. A transition while `fn_enable` is low is dropped, with no pending bit and no message.
- R7: A request that arrives while `fn_mask` is high or the vector's control bit 0 is 1 sets the pending bit and sends no message. No message starts while `fn_mask` is high.
- R8: A host write to any dword of entry i checks vector i. If it is pending and unmasked, its message is sent and its pending bit is cleared.
- R9: A `rescan` pulse checks all vectors in ascending order with the rule of R8. Masked vectors stay pending. Clearing `fn_mask` without a rescan sends nothing.
- R10: `msg_valid` stays high, with `msg_addr` and `msg_data` stable, until `msg_ready` is sampled high. Vectors requested in the same cycle are sent one at a time, lowest index first, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address within the region |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | input | NVEC | Per-vector interrupt request lines |
| fn_enable | input | 1 | Function-level message enable |
| fn_mask | input | 1 | Function-level mask |
| rescan | input | 1 | Pulse: recheck all pending vectors |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message payload |

## Verification
A pending bit that is stuck, or one that is lost, can be seen at the ports. It shows in the pending dword on the next read. It also shows two cycles after the entry write or rescan that should replay it, either as an extra message or as a missing one. A wrong selection among the vectors waiting to be checked shows up when two vectors are requested at once under backpressure: the order of the two accepted messages is wrong. The bench also checks that stored address bits and masks reach the message fields unchanged, and that accesses to the pending array, to addresses beyond the region and to misaligned addresses leave the state as it was.

// File: rtl/msix_vec_table.sv
module msix_vec_table #(
  parameter int NVEC   = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NVEC-1:0]   irq_req,
  input  logic              fn_enable,
  input  logic              fn_mask,
  input  logic              rescan,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam int unsigned VW      = $clog2(NVEC);
  localparam int unsigned IDX_W   = VW + 2;
  localparam int unsigned NDW     = NVEC * 4;
  localparam int unsigned PBA_OFF = NVEC * 16;
  localparam int unsigned PBA_DW  = (NVEC + 31) / 32;
  localparam int unsigned PBA_B   = (NVEC + 7) / 8;
  localparam int unsigned REGION  = ((PBA_OFF + PBA_B + 4095) / 4096) * 4096;

  logic [31:0]         tbl [NDW];
  logic [NVEC-1:0]     pend, chk, irq_q, msk, rise;
  logic [NVEC-1:0]     pend_n, chk_n;
  logic [PBA_DW*32-1:0] pend_ext;
  logic [VW-1:0]       sel;
  logic                sel_hit, launch;
  logic [31:0]         a32;
  logic [IDX_W-1:0]    idx;
  logic [VW-1:0]       wvec;
  logic                wr_ok;

  assign a32   = 32'(bus_addr);
  assign idx   = bus_addr[IDX_W+1:2];
  assign wvec  = bus_addr[IDX_W+1:4];
  assign wr_ok = bus_wr && (bus_addr[1:0] == 2'b00) && (a32 < PBA_OFF);
  assign rise  = irq_req & ~irq_q;

  for (genvar i = 0; i < NVEC; i++) begin : g_msk
    assign msk[i] = tbl[4*i+3][0];
  end

  always_comb begin
    sel_hit = 1'b0;
    sel     = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (chk[i]) begin
        sel_hit = 1'b1;
        sel     = VW'(i);
      end
    end
  end

  assign launch = !msg_valid && sel_hit && fn_enable && !fn_mask &&
                  pend[sel] && !msk[sel];

  always_comb begin
    pend_n = pend;
    chk_n  = chk;
    if (!msg_valid && sel_hit) chk_n[sel] = 1'b0;
    if (launch) pend_n[sel] = 1'b0;
    if (rescan) chk_n = '1;
    if (wr_ok) chk_n[wvec] = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      if (fn_enable && rise[i]) begin
        pend_n[i] = 1'b1;
        if (!fn_mask && !msk[i]) chk_n[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(NDW); k++) tbl[k] <= ((k % 4) == 3) ? 32'd1 : 32'd0;
      pend      <= '0;
      chk       <= '0;
      irq_q     <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      irq_q <= irq_req;
      pend  <= pend_n;
      chk   <= chk_n;
      if (wr_ok) tbl[idx] <= bus_wdata;
      if (launch) begin
        msg_valid <= 1'b1;
        msg_addr  <= {tbl[{sel, 2'b01}], tbl[{sel, 2'b00}][31:2], 2'b00};
        msg_data  <= tbl[{sel, 2'b10}];
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    pend_ext = '0;
    pend_ext[NVEC-1:0] = pend;
  end

  always_comb begin
    if (bus_addr[1:0] != 2'b00 || a32 >= REGION) begin
      bus_rdata = '1;
    end else if (a32 < PBA_OFF) begin
      bus_rdata = tbl[idx];
    end else begin
      bus_rdata = '0;
      for (int k = 0; k < int'(PBA_DW); k++)
        if (a32 == PBA_OFF + 32'(4 * k)) bus_rdata = pend_ext[k*32 +: 32];
    end
  end
endmodule

module msix_vec_table_chk #(
  parameter int NVEC   = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              fn_mask,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [63:0]       msg_addr,
  input logic [31:0]       msg_data
);
  localparam int unsigned REGION = ((NVEC * 16 + (NVEC + 7) / 8 + 4095) / 4096) * 4096;

  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_addr[1:0] == 2'b00);

  // R7
  fn_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fn_mask && !msg_valid |=> !msg_valid);

  // R4
  beyond_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bus_addr) >= REGION |-> bus_rdata == 32'hFFFF_FFFF);

  // R5
  misaligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[1:0] != 2'b00 |-> bus_rdata == 32'hFFFF_FFFF);
endmodule

bind msix_vec_table msix_vec_table_chk #(.NVEC(NVEC), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .fn_mask(fn_mask), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/msix_vec_table_tb.sv
module msix_vec_table_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam int AW   = 16;
  localparam logic [15:0] PBA = 16'h0080;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NVEC-1:0] irq_req = '0;
  logic fn_enable = 1'b1, fn_mask = 1'b0, rescan = 1'b0;
  logic msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0, errors = 0, ncap = 0;
  logic [63:0] cap_addr [64];
  logic [31:0] cap_data [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  msix_vec_table #(.NVEC(NVEC), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .fn_enable(fn_enable), .fn_mask(fn_mask), .rescan(rescan),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  always @(negedge clk)
    if (rst_n && msg_valid && msg_ready && ncap < 64) begin
      cap_addr[ncap] = msg_addr;
      cap_data[ncap] = msg_data;
      ncap++;
    end

  // {address, write data, expected readback}
  localparam logic [79:0] VEC [10] = '{
    {16'h0000, 32'h1234_5678, 32'h1234_5678},
    {16'h0004, 32'h0000_00AB, 32'h0000_00AB},
    {16'h0008, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {16'h000C, 32'hFFFF_FFFE, 32'hFFFF_FFFE},
    {16'h0010, 32'hCAFE_0001, 32'hCAFE_0001},
    {16'h001C, 32'h0000_0003, 32'h0000_0003},
    {16'h0078, 32'h0BAD_F00D, 32'h0BAD_F00D},
    {16'h0080, 32'h0000_00FF, 32'h0000_0000},
    {16'h0F00, 32'h1111_1111, 32'h0000_0000},
    {16'h0005, 32'h2222_2222, 32'hFFFF_FFFF}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(string req, logic [15:0] a, logic [31:0] exp);
    bus_addr = a;
    @(negedge clk);
    chk(req, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic pulse(logic [NVEC-1:0] v);
    @(posedge clk); #1;
    irq_req = v;
    @(posedge clk); #1;
    irq_req = '0;
  endtask

  task automatic prog(int v, logic [31:0] lo, logic [31:0] hi, logic [31:0] d, logic [31:0] c);
    wr(16'(v*16),     lo);
    wr(16'(v*16 + 4), hi);
    wr(16'(v*16 + 8), d);
    wr(16'(v*16 + 12), c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd("R1 ctrl v0", 16'h000C, 32'h1);
    rd("R1 ctrl v7", 16'h007C, 32'h1);
    rd("R1 addr v3", 16'h0030, 32'h0);
    rd("R1 pending", PBA, 32'h0);
    chk("R1 msg_valid", 64'(msg_valid), 64'(0));

    // R2 / R5 vector table walk
    for (int k = 0; k < 10; k++) begin
      wr(VEC[k][79:64], VEC[k][63:32]);
      rd("R2/R5 table walk", VEC[k][79:64], VEC[k][31:0]);
    end
    rd("R5 misaligned write ignored", 16'h0004, 32'h0000_00AB);
    rd("R4 beyond region", 16'h1000, 32'hFFFF_FFFF);
    rd("R4 last reserved dword", 16'h0FFC, 32'h0);

    prog(2, 32'h1000_0003, 32'h0000_000A, 32'h22, 32'h0);
    prog(3, 32'h2000_0000, 32'h0000_0000, 32'h33, 32'h1);
    prog(4, 32'h4000_0004, 32'h0000_000B, 32'h44, 32'h0);
    prog(5, 32'h5000_0000, 32'h0000_0000, 32'h55, 32'h1);
    idle(3);
    chk("R8 no spurious messages on programming", 64'(ncap), 64'(0));

    // R3 unmasked request
    pulse(8'h04);
    idle(4);
    chk("R3 one message", 64'(ncap), 64'(1));
    chk("R3 address low bits cleared", cap_addr[0], 64'h0000_000A_1000_0000);
    chk("R3 payload", 64'(cap_data[0]), 64'h22);
    rd("R3 pending cleared", PBA, 32'h0);

    // R7 / R8 masked vector, then unmask by entry write
    pulse(8'h08);
    idle(4);
    chk("R7 masked sends nothing", 64'(ncap), 64'(1));
    rd("R4 R7 pending bit 3", PBA, 32'h08);
    wr(16'h003C, 32'h0);
    idle(4);
    chk("R8 replay on write", 64'(ncap), 64'(2));
    chk("R8 replay data", 64'(cap_data[1]), 64'h33);
    rd("R8 pending cleared", PBA, 32'h0);

    // R9 function mask, rescan
    fn_mask = 1'b1;
    pulse(8'h04);
    pulse(8'h20);
    idle(4);
    chk("R7 fn masked", 64'(ncap), 64'(2));
    rd("R7 pending 2 and 5", PBA, 32'h24);
    fn_mask = 1'b0;
    idle(5);
    chk("R9 unmask alone silent", 64'(ncap), 64'(2));
    @(posedge clk); #1; rescan = 1'b1;
    @(posedge clk); #1; rescan = 1'b0;
    idle(6);
    chk("R9 rescan replay", 64'(ncap), 64'(3));
    chk("R9 rescan vector 2", 64'(cap_data[2]), 64'h22);
    rd("R9 masked stays pending", PBA, 32'h20);

    // R5 write to pending array ignored
    wr(PBA, 32'h0);
    rd("R5 pending write ignored", PBA, 32'h20);

    // R10 backpressure and order
    msg_ready = 1'b0;
    pulse(8'h14);
    idle(5);
    chk("R10 valid held", 64'(msg_valid), 64'(1));
    chk("R10 lowest first", msg_addr, 64'h0000_000A_1000_0000);
    chk("R10 no accept", 64'(ncap), 64'(3));
    msg_ready = 1'b1;
    idle(6);
    chk("R10 both delivered", 64'(ncap), 64'(5));
    chk("R10 first vec2", 64'(cap_data[3]), 64'h22);
    chk("R10 second vec4", cap_addr[4], 64'h0000_000B_4000_0004);

    // R6 held level, enable low
    @(posedge clk); #1; irq_req = 8'h04;
    idle(10);
    irq_req = '0;
    idle(3);
    chk("R6 held level one message", 64'(ncap), 64'(6));
    base = ncap;
    fn_enable = 1'b0;
    pulse(8'h04);
    idle(3);
    fn_enable = 1'b1;
    idle(3);
    chk("R6 disabled request dropped", 64'(ncap), 64'(base));
    rd("R6 no pending from disabled", PBA, 32'h20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule